// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block lets a management agent that only speaks clause-22 MDIO reach a 32-bit, word-aligned register space inside a switch. It receives MDIO transactions that have already been parsed, each carrying a PHY address, a register number, a read/write flag and 16 bits of write data. From these it builds complete 32-bit reads and writes on a simple internal register bus.

The register address comes from three sources. A page register at PHY address 0x1F, register 0x10 holds the upper nine word-index bits. The low three bits of a PHY address in the group 0x10 to 0x17 supply the middle three bits. Bits 4:1 of the MDIO register number supply the low four bits. Bit 0 of the register number picks the half of the word: an even register carries bits 15:0 and the next odd register carries bits 31:16.

Reads go low half first. The even read fetches the whole word and keeps the upper half for the odd read that follows. Writes go high half first. The odd write is only held in the bridge. The even write then commits all 32 bits in one bus write.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page register is zero, `rdValid` is low, and neither `busRead` nor `busWrite` is asserted.
- R2: A write to PHY 0x1F, register 0x10 stores `txnWdata[8:0]` as the page. A read of that same address returns the page zero-extended on `rdData`, with `rdValid` high for one cycle on the cycle after the request.
- R3: For a data access, `busAddr` equals {page, PHY[2:0], REG[4:1], 2'b00}, which is the word index shifted left by two.
- R4: A read of an even register in the group asserts `busRead` in the same cycle. On the next cycle `rdData` holds `busRdata[15:0]` and `rdValid` is high.
- R5: A read of an odd register in the group makes no bus access. It returns the bits 31:16 that the most recent even read captured, or zero if no even read has happened since reset, with `rdValid` high on the next cycle.
- R6: A write to an odd register in the group makes no bus access. It holds the 16 data bits as the pending upper half.
- R7: A write to an even register in the group asserts `busWrite` in the same cycle, with `busWdata` = {pending upper half, `txnWdata`}. The pending upper half then returns to zero.
- R8: An even-register write with no odd write before it since the last commit writes zero in bits 31:16.
- R9: Any access outside the group 0x10 to 0x17, other than the page register itself, has no effect. It makes no bus access, produces no `rdValid` pulse and leaves the page unchanged.
- R10: Page-register write data bits 15:9 are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| txnValid | input | 1 | A parsed MDIO transaction is present this cycle |
| txnWrite | input | 1 | 1 = write, 0 = read |
| txnPhy | input | 5 | PHY address of the transaction |
| txnReg | input | 5 | Register number of the transaction |
| txnWdata | input | 16 | Write data of the transaction |
| rdValid | output | 1 | Read response valid, one cycle |
| rdData | output | 16 | Read response data |
| busRead | output | 1 | Internal bus 32-bit read strobe |
| busWrite | output | 1 | Internal bus 32-bit write strobe |
| busAddr | output | 18 | Internal bus byte address |
| busWdata | output | 32 | Internal bus write data |
| busRdata | input | 32 | Internal bus read data, valid in the cycle of `busRead` |

## Verification
The bus strobes, address and write data are combinational from the transaction, so the bench samples them shortly after it drives a request, within the same cycle. Read responses pass through one register: `rdValid` and `rdData` are due on the cycle after the request, and the bench samples them at the following falling edge. The pending upper half and the captured read half persist across transactions. Each scenario therefore sends its ordered pair of halves back to back and checks the combined result, including the zero upper half after a commit and the lack of effect from accesses outside the group.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  // Per-transaction decode results passed from control to datapath
  typedef struct packed {
    logic pageWr;   // store page register
    logic pageRd;   // return page register
    logic wordRd;   // even-register read: fetch whole word
    logic hiRd;     // odd-register read: return captured upper half
    logic hiWr;     // odd-register write: hold upper half
    logic wordWr;   // even-register write: commit whole word
  } bridge_strobe_t;

endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int          PHY_W      = 5,
  parameter int          REG_W      = 5,
  parameter int          SEL_W      = 3,
  parameter logic [4:0]  PAGE_PHY   = 5'h1F,
  parameter logic [4:0]  PAGE_REG   = 5'h10,
  parameter logic [4:0]  GROUP_BASE = 5'h10
) (
  input  logic             txnValid,
  input  logic             txnWrite,
  input  logic [PHY_W-1:0] txnPhy,
  input  logic [REG_W-1:0] txnReg,
  output bridge_strobe_t   strb
);

  localparam int GRP_TOP_W = PHY_W - SEL_W;

  logic inGroup;
  logic isPage;
  logic lowHalf;

  // Group membership: upper PHY bits match the group base
  assign inGroup = (txnPhy[PHY_W-1:SEL_W] == GROUP_BASE[PHY_W-1:SEL_W]);
  assign isPage  = (txnPhy == PAGE_PHY[PHY_W-1:0]) && (txnReg == PAGE_REG[REG_W-1:0]);
  assign lowHalf = ~txnReg[0];

  always_comb begin
    strb = '0;
    if (txnValid) begin
      if (isPage) begin
        strb.pageWr = txnWrite;
        strb.pageRd = ~txnWrite;
      end else if (inGroup) begin
        strb.wordRd = ~txnWrite & lowHalf;
        strb.hiRd   = ~txnWrite & ~lowHalf;
        strb.hiWr   = txnWrite & ~lowHalf;
        strb.wordWr = txnWrite & lowHalf;
      end
    end
  end

  // At most one action per transaction
  always_comb begin
    assert_one_action_R9: assert ($onehot0(strb));
  end

  logic unusedGrpW;
  assign unusedGrpW = (GRP_TOP_W == 0);

endmodule

// File: rtl/mdio_bridge_dp.sv
module mdio_bridge_dp
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int SEL_W  = 3,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int IDX_W  = PAGE_W + SEL_W + REG_W - 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridge_strobe_t    strb,
  input  logic [PHY_W-1:0]  txnPhy,
  input  logic [REG_W-1:0]  txnReg,
  input  logic [HALF_W-1:0] txnWdata,
  input  logic [WORD_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  output logic              rdValid,
  output logic [HALF_W-1:0] rdData
);

  logic [PAGE_W-1:0] pageQ;
  logic [HALF_W-1:0] rdHiQ;   // upper half captured by last even read
  logic [HALF_W-1:0] wrHiQ;   // pending upper half for next even write
  logic [IDX_W-1:0]  wordIdx;
  logic              pageUnused;

  assign pageUnused = ^txnWdata[HALF_W-1:PAGE_W] ^ ^txnPhy[PHY_W-1:SEL_W];

  assign wordIdx  = {pageQ, txnPhy[SEL_W-1:0], txnReg[REG_W-1:1]};
  assign busAddr  = {wordIdx, 2'b00};
  assign busWdata = {wrHiQ, txnWdata};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ <= '0;
    end else if (strb.pageWr) begin
      pageQ <= txnWdata[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrHiQ <= '0;
    end else if (strb.hiWr) begin
      wrHiQ <= txnWdata;
    end else if (strb.wordWr) begin
      wrHiQ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHiQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.pageRd | strb.wordRd | strb.hiRd;
      if (strb.pageRd) begin
        rdData <= {{(HALF_W-PAGE_W){1'b0}}, pageQ};
      end else if (strb.wordRd) begin
        rdData <= busRdata[HALF_W-1:0];
        rdHiQ  <= busRdata[WORD_W-1:HALF_W];
      end else if (strb.hiRd) begin
        rdData <= rdHiQ;
      end
    end
  end

  // Page only moves on a page write
  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pageWr |=> $stable(pageQ));

  // Upper half returns to zero after a commit
  assert_hi_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordWr |=> (wrHiQ == '0));

  // Odd read returns the previously captured half
  assert_hi_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.hiRd |=> (rdData == $past(rdHiQ)));

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int SEL_W  = 3,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = PAGE_W + SEL_W + REG_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnValid,
  input  logic              txnWrite,
  input  logic [PHY_W-1:0]  txnPhy,
  input  logic [REG_W-1:0]  txnReg,
  input  logic [HALF_W-1:0] txnWdata,
  output logic              rdValid,
  output logic [HALF_W-1:0] rdData,
  output logic              busRead,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] busRdata
);

  bridge_strobe_t strb;

  mdio_bridge_ctrl #(
    .PHY_W(PHY_W), .REG_W(REG_W), .SEL_W(SEL_W)
  ) i_ctrl (
    .txnValid(txnValid), .txnWrite(txnWrite),
    .txnPhy(txnPhy), .txnReg(txnReg), .strb(strb)
  );

  mdio_bridge_dp #(
    .PAGE_W(PAGE_W), .SEL_W(SEL_W), .PHY_W(PHY_W), .REG_W(REG_W), .HALF_W(HALF_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txnPhy(txnPhy), .txnReg(txnReg), .txnWdata(txnWdata),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .rdValid(rdValid), .rdData(rdData)
  );

  assign busRead  = strb.wordRd;
  assign busWrite = strb.wordWr;

  // A bus read is always answered on the next cycle
  assert_rd_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    busRead |=> rdValid);

  // No bus activity without a transaction
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !txnValid |-> (!busRead && !busWrite));

  // Response never appears without a request one cycle earlier
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !txnValid |=> !rdValid);

endmodule

// File: tb/test_mdio_page_bridge.sv
module test_mdio_page_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txnValid = 1'b0;
  logic        txnWrite = 1'b0;
  logic [4:0]  txnPhy = '0;
  logic [4:0]  txnReg = '0;
  logic [15:0] txnWdata = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic        busRead;
  logic        busWrite;
  logic [17:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // captured results of the last transaction
  logic        sRd, sWr, sValid;
  logic [17:0] sAddr;
  logic [31:0] sWdata;
  logic [15:0] sData;

  always #5 clk = ~clk;

  mdio_page_bridge i_mdio_page_bridge (
    .clk(clk), .rstN(rstN), .txnValid(txnValid), .txnWrite(txnWrite),
    .txnPhy(txnPhy), .txnReg(txnReg), .txnWdata(txnWdata),
    .rdValid(rdValid), .rdData(rdData), .busRead(busRead), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [31:0] modelWord(input logic [17:0] a);
    return {a[17:2] ^ 16'h5A3C, ~a[17:2]};
  endfunction

  function automatic logic [17:0] expAddr(input int page, input int phy, input int rg);
    return 18'(((page << 7) | ((phy & 7) << 4) | (rg >> 1)) << 2);
  endfunction

  assign busRdata = modelWord(busAddr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doTxn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd);
    @(negedge clk);
    txnValid = 1'b1; txnWrite = wr; txnPhy = phy; txnReg = rg; txnWdata = wd;
    #1;
    sRd = busRead; sWr = busWrite; sAddr = busAddr; sWdata = busWdata;
    @(negedge clk);
    txnValid = 1'b0;
    sValid = rdValid; sData = rdData;
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R1 rdValid", 32'(rdValid), 0);
    check("R1 busRead", 32'(busRead), 0);
    check("R1 busWrite", 32'(busWrite), 0);
    doTxn(0, 5'h1F, 5'h10, 0);
    check("R1 page after reset", 32'(sData), 0);
  endtask

  task automatic testPage;
    doTxn(1, 5'h1F, 5'h10, 16'hFFAB);
    check("R2 page write no bus", 32'(sRd | sWr), 0);
    doTxn(0, 5'h1F, 5'h10, 0);
    check("R2 page rdValid", 32'(sValid), 1);
    check("R10 page readback", 32'(sData), 32'h01AB);
  endtask

  task automatic testRead;
    logic [31:0] w;
    doTxn(0, 5'h13, 5'h0A, 0);
    w = modelWord(expAddr(9'h1AB, 3, 10));
    check("R4 busRead", 32'(sRd), 1);
    check("R3 read address", 32'(sAddr), 32'(expAddr(9'h1AB, 3, 10)));
    check("R4 rdValid", 32'(sValid), 1);
    check("R4 low half", 32'(sData), 32'(w[15:0]));
    doTxn(0, 5'h13, 5'h0B, 0);
    check("R5 no bus on odd read", 32'(sRd), 0);
    check("R5 rdValid", 32'(sValid), 1);
    check("R5 high half", 32'(sData), 32'(w[31:16]));
  endtask

  task automatic testWrite;
    doTxn(1, 5'h15, 5'h07, 16'hBEEF);
    check("R6 no bus on odd write", 32'(sWr | sRd), 0);
    check("R6 no response", 32'(sValid), 0);
    doTxn(1, 5'h15, 5'h06, 16'h1234);
    check("R7 busWrite", 32'(sWr), 1);
    check("R7 write data", sWdata, 32'hBEEF1234);
    check("R3 write address", 32'(sAddr), 32'(expAddr(9'h1AB, 5, 6)));
  endtask

  task automatic testNoHigh;
    doTxn(1, 5'h10, 5'h1E, 16'hCAFE);
    check("R8 busWrite", 32'(sWr), 1);
    check("R8 zero upper", sWdata, 32'h0000CAFE);
  endtask

  task automatic testIgnore;
    doTxn(1, 5'h05, 5'h10, 16'h0055);
    check("R9 write outside group no bus", 32'(sRd | sWr), 0);
    doTxn(0, 5'h18, 5'h02, 0);
    check("R9 read outside group no bus", 32'(sRd), 0);
    check("R9 read outside group no response", 32'(sValid), 0);
    doTxn(1, 5'h1F, 5'h11, 16'h0077);
    doTxn(0, 5'h1F, 5'h10, 0);
    check("R9 page unchanged", 32'(sData), 32'h01AB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset;
    testPage;
    testRead;
    testWrite;
    testNoHigh;
    testIgnore;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule